// File: doc/BRIEF.md
# Clock Power Management Switchback Controller

This block decides how fast the core clock runs and tells an external clock-control unit what to do. Software programs a small control register through a write port. The register picks one of three operating states: full speed, reduced frequency with a programmable divider, or stop, where the clock is halted completely. The block does not make clocks. It only presents registered requests: a stop request, a slow request and a divider select. The clock unit answers each change through a request/acknowledge handshake.

The switchback feature brings a slowed core back to full speed on its own. Two triggers can do this, and each has its own enable bit: serial activity, where any UART reports it is busy, and interrupts, where an enabled interrupt is pending or an interrupt service routine is active. The block drops back to the reduced rate once the UART is idle and no interrupt is pending or in service. In stop mode, any pending enabled interrupt clears the stop setting in the control register, so the core wakes at full speed.

Top module: `pwr_switchback_ctrl`

## Requirements
- R1: After synchronous reset the outputs show full speed (`clk_stop`=0, `clk_slow`=0, `clk_div_sel`=0, `chg_req`=0), and both switchback enables are cleared.
- R2: A write with `cfg_we`=1 loads the control register from `cfg_wdata`. Bits [1:0] select the mode: 0 is full, 1 is reduced, 2 is stop, and 3 is treated as full. Bit 2 enables the UART switchback. Bit 3 enables the interrupt switchback. Bits [DIV_W+3:4] hold the divider select.
- R3: In reduced mode with no switchback active, the outputs are `clk_slow`=1 and `clk_stop`=0, and `clk_div_sel` equals the divider field. In every other state `clk_div_sel` is 0.
- R4: In stop mode the outputs are `clk_stop`=1 and `clk_slow`=0.
- R5: In stop mode, any bit of `irq_pend` set at a clock edge changes the stored mode to full at that edge. The clock then resumes at full speed and stays there after the interrupt clears.
- R6: In reduced mode with the UART enable set, any bit of `uart_busy` raises the presented clock to full speed. The change is presented two edges after the busy flag is first sampled.
- R7: In reduced mode with the interrupt enable set, a pending interrupt or `irq_active` raises the presented clock to full speed.
- R8: When the matching enable bit is clear, UART activity and interrupts have no effect on the reduced clock.
- R9: Once switchback is active, the block returns to the reduced rate only when no UART is busy, `irq_active` is 0 and no interrupt is pending.
- R10: Each change of the presented outputs is issued together with a rising `chg_req`. `chg_req` stays high until `chg_ack` is sampled high. While it is high the presented outputs do not change, and it is low in the cycle after the acknowledge.
- R11: `clk_stop` and `clk_slow` are never high together.
- R12: A register write in the same cycle as a stop-mode interrupt wake takes priority over the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | DIV_W+4 | Control register write data |
| uart_busy | input | N_UART | Per-UART activity flags |
| irq_pend | input | N_IRQ | Enabled pending interrupt flags |
| irq_active | input | 1 | An interrupt service routine is running |
| chg_ack | input | 1 | Clock unit acknowledge of the current request |
| clk_stop | output | 1 | Request to halt the core clock |
| clk_slow | output | 1 | Request to run at the reduced rate |
| clk_div_sel | output | DIV_W | Divider select for the reduced rate |
| chg_req | output | 1 | A new clock setting is presented and awaits acknowledge |

## Verification
The assertions check the handshake rules on every cycle. These are: outputs are frozen while a request is outstanding, each output change comes with a rising request, the request drops after an acknowledge, and stop and slow are never requested together. The same checks cover the stop-mode wake in the register and the full-speed state after reset. The bench scenarios are the only place where the events are tied to the right outcome. They check that UART traffic or an interrupt raises the clock only when the matching enable is set, that the drop back waits for UART idle and for interrupt service to end, that a write beats a wake in the same cycle, and the exact edge at which each change appears.

// File: rtl/pwr_sb_pkg.sv
package pwr_sb_pkg;
  typedef enum logic [1:0] {
    PM_FULL = 2'd0,
    PM_SLOW = 2'd1,
    PM_STOP = 2'd2
  } pm_mode_e;

  localparam int MODE_LSB   = 0;
  localparam int UART_EN_B  = 2;
  localparam int IRQ_EN_B   = 3;
  localparam int DIV_LSB    = 4;
endpackage

// File: rtl/pwr_cfg_reg.sv
module pwr_cfg_reg
  import pwr_sb_pkg::*;
#(
  parameter int DIV_W = 3,
  localparam int CFG_W = DIV_W + DIV_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             wake,
  output pm_mode_e         mode,
  output logic             sb_uart_en,
  output logic             sb_irq_en,
  output logic [DIV_W-1:0] div
);
  pm_mode_e wr_mode;

  always_comb begin
    case (wdata[MODE_LSB +: 2])
      2'd1:    wr_mode = PM_SLOW;
      2'd2:    wr_mode = PM_STOP;
      default: wr_mode = PM_FULL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= PM_FULL;
      sb_uart_en <= 1'b0;
      sb_irq_en  <= 1'b0;
      div        <= '0;
    end else if (we) begin
      mode       <= wr_mode;
      sb_uart_en <= wdata[UART_EN_B];
      sb_irq_en  <= wdata[IRQ_EN_B];
      div        <= wdata[DIV_LSB +: DIV_W];
    end else if (mode == PM_STOP && wake) begin
      mode <= PM_FULL;
    end
  end
endmodule

// File: rtl/pwr_boost.sv
module pwr_boost
  import pwr_sb_pkg::*;
#(
  parameter int N_UART = 2,
  parameter int N_IRQ  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  pm_mode_e          mode,
  input  logic              sb_uart_en,
  input  logic              sb_irq_en,
  input  logic [N_UART-1:0] uart_busy,
  input  logic [N_IRQ-1:0]  irq_pend,
  input  logic              irq_active,
  output logic              boosted
);
  logic uart_any, irq_any, trig, hold;

  assign uart_any = |uart_busy;
  assign irq_any  = (|irq_pend) | irq_active;
  assign trig     = (sb_uart_en & uart_any) | (sb_irq_en & irq_any);
  assign hold     = uart_any | irq_any;

  always_ff @(posedge clk) begin
    if (rst) boosted <= 1'b0;
    else     boosted <= (mode == PM_SLOW) && (trig || (boosted && hold));
  end
endmodule

// File: rtl/pwr_clk_req.sv
module pwr_clk_req #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tgt_stop,
  input  logic             tgt_slow,
  input  logic [DIV_W-1:0] tgt_div,
  input  logic             ack,
  output logic             stop,
  output logic             slow,
  output logic [DIV_W-1:0] div,
  output logic             req
);
  logic differs;

  assign differs = (tgt_stop != stop) || (tgt_slow != slow) || (tgt_div != div);

  always_ff @(posedge clk) begin
    if (rst) begin
      stop <= 1'b0;
      slow <= 1'b0;
      div  <= '0;
      req  <= 1'b0;
    end else if (req) begin
      if (ack) req <= 1'b0;
    end else if (differs) begin
      stop <= tgt_stop;
      slow <= tgt_slow;
      div  <= tgt_div;
      req  <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_switchback_ctrl.sv
module pwr_switchback_ctrl
  import pwr_sb_pkg::*;
#(
  parameter int DIV_W  = 3,
  parameter int N_UART = 2,
  parameter int N_IRQ  = 4,
  localparam int CFG_W = DIV_W + DIV_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [N_UART-1:0] uart_busy,
  input  logic [N_IRQ-1:0]  irq_pend,
  input  logic              irq_active,
  input  logic              chg_ack,
  output logic              clk_stop,
  output logic              clk_slow,
  output logic [DIV_W-1:0]  clk_div_sel,
  output logic              chg_req
);
  pm_mode_e         mode_q;
  logic             sb_uart_en, sb_irq_en, boosted;
  logic [DIV_W-1:0] div_q;
  logic             tgt_stop, tgt_slow;
  logic [DIV_W-1:0] tgt_div;

  pwr_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .wake(|irq_pend),
    .mode(mode_q), .sb_uart_en(sb_uart_en), .sb_irq_en(sb_irq_en), .div(div_q)
  );

  pwr_boost #(.N_UART(N_UART), .N_IRQ(N_IRQ)) u_boost (
    .clk(clk), .rst(rst), .mode(mode_q), .sb_uart_en(sb_uart_en),
    .sb_irq_en(sb_irq_en), .uart_busy(uart_busy), .irq_pend(irq_pend),
    .irq_active(irq_active), .boosted(boosted)
  );

  assign tgt_stop = (mode_q == PM_STOP);
  assign tgt_slow = (mode_q == PM_SLOW) && !boosted;
  assign tgt_div  = tgt_slow ? div_q : '0;

  pwr_clk_req #(.DIV_W(DIV_W)) u_req (
    .clk(clk), .rst(rst), .tgt_stop(tgt_stop), .tgt_slow(tgt_slow),
    .tgt_div(tgt_div), .ack(chg_ack), .stop(clk_stop), .slow(clk_slow),
    .div(clk_div_sel), .req(chg_req)
  );
endmodule

// File: rtl/pwr_switchback_chk.sv
module pwr_switchback_chk
  import pwr_sb_pkg::*;
#(
  parameter int DIV_W = 3,
  parameter int N_IRQ = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [N_IRQ-1:0] irq_pend,
  input logic             chg_ack,
  input logic             clk_stop,
  input logic             clk_slow,
  input logic [DIV_W-1:0] clk_div_sel,
  input logic             chg_req,
  input pm_mode_e         mode_q
);
  assert_reset_full_R1: assert property (@(posedge clk)
    rst |=> (!clk_stop && !clk_slow && !chg_req && clk_div_sel == '0));

  assert_stop_wake_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_STOP && (|irq_pend) && !cfg_we) |=> (mode_q == PM_FULL));

  assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (chg_req && !chg_ack) |=> ($stable(clk_stop) && $stable(clk_slow) && $stable(clk_div_sel)));

  assert_req_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (chg_req && chg_ack) |=> !chg_req);

  assert_change_has_req_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable({clk_stop, clk_slow, clk_div_sel}) |-> $rose(chg_req));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(clk_stop && clk_slow));

  assert_div_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !clk_slow |-> (clk_div_sel == '0));
endmodule

bind pwr_switchback_ctrl pwr_switchback_chk #(.DIV_W(DIV_W), .N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .irq_pend(irq_pend), .chg_ack(chg_ack),
  .clk_stop(clk_stop), .clk_slow(clk_slow), .clk_div_sel(clk_div_sel),
  .chg_req(chg_req), .mode_q(mode_q)
);

// File: tb/pwr_switchback_ctrl_bench.sv
module pwr_switchback_ctrl_bench;
  localparam int DIV_W = 3, N_UART = 2, N_IRQ = 4;

  logic clk = 0, rst = 1, cfg_we = 0, irq_active = 0, chg_ack = 0;
  logic [DIV_W+3:0]  cfg_wdata = '0;
  logic [N_UART-1:0] uart_busy = '0;
  logic [N_IRQ-1:0]  irq_pend = '0;
  logic clk_stop, clk_slow, chg_req;
  logic [DIV_W-1:0] clk_div_sel;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_switchback_ctrl #(.DIV_W(DIV_W), .N_UART(N_UART), .N_IRQ(N_IRQ)) u_pwr_switchback_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .uart_busy(uart_busy),
    .irq_pend(irq_pend), .irq_active(irq_active), .chg_ack(chg_ack), .clk_stop(clk_stop),
    .clk_slow(clk_slow), .clk_div_sel(clk_div_sel), .chg_req(chg_req)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // mode: 0 full, 1 reduced, 2 stop, 3 full
  task automatic wr(int mode, bit uen, bit ien, int dv);
    cfg_wdata = {dv[DIV_W-1:0], ien, uen, mode[1:0]};
    cfg_we = 1;
    tick();
    cfg_we = 0;
  endtask

  task automatic settle();
    for (int i = 0; i < 6; i++) begin
      if (chg_req) begin
        chg_ack = 1; tick(); chg_ack = 0;
      end else tick();
    end
  endtask

  function automatic int outs();
    return {clk_stop, clk_slow, clk_div_sel};
  endfunction

  task automatic t_reset();
    chk("R1 stop", clk_stop, 0);
    chk("R1 slow", clk_slow, 0);
    chk("R1 div", clk_div_sel, 0);
    chk("R1 req", chg_req, 0);
  endtask

  task automatic t_handshake();
    wr(1, 0, 0, 5);
    chk("R10 req before present", chg_req, 0);
    chk("R10 slow before present", clk_slow, 0);
    tick();
    chk("R10 req raised", chg_req, 1);
    chk("R3 slow", clk_slow, 1);
    chk("R3 div", clk_div_sel, 5);
    tick(); tick();
    chk("R10 req held", chg_req, 1);
    wr(0, 0, 0, 0);
    tick();
    chk("R10 frozen", clk_slow, 1);
    chg_ack = 1; tick(); chg_ack = 0;
    chk("R10 req dropped", chg_req, 0);
    chk("R10 still frozen", clk_slow, 1);
    tick();
    chk("R10 next req", chg_req, 1);
    chk("R2 full after write", clk_slow, 0);
    chk("R3 div zero at full", clk_div_sel, 0);
    settle();
  endtask

  task automatic t_reset_sb_off();
    // R1: enables cleared by reset: reduced via a write that keeps enables 0 equals reset state
    wr(1, 0, 0, 2); settle();
    uart_busy = 2'b01; irq_pend = 4'b0010; settle();
    chk("R8 uart/irq ignored slow", clk_slow, 1);
    chk("R8 div kept", clk_div_sel, 2);
    uart_busy = '0; irq_pend = '0; settle();
  endtask

  task automatic t_uart_boost();
    wr(1, 1, 0, 3); settle();
    chk("R3 reduced", outs(), 'b01011);
    uart_busy = 2'b10; tick();
    chk("R6 not yet", clk_slow, 1);
    tick();
    chk("R6 boosted", clk_slow, 0);
    chk("R6 req", chg_req, 1);
    settle();
    irq_pend = 4'b0100; settle();
    chk("R8 irq alone with uart enable only, still full", clk_slow, 0);
    uart_busy = '0; irq_active = 1; settle();
    chk("R9 held by pending/active", clk_slow, 0);
    irq_pend = '0; settle();
    chk("R9 held by active", clk_slow, 0);
    irq_active = 0; settle();
    chk("R9 back to reduced", outs(), 'b01011);
    irq_pend = 4'b0001; settle();
    chk("R8 irq ignored when disabled", clk_slow, 1);
    irq_pend = '0; settle();
  endtask

  task automatic t_irq_boost();
    wr(1, 0, 1, 6); settle();
    uart_busy = 2'b01; settle();
    chk("R8 uart ignored when disabled", clk_slow, 1);
    uart_busy = '0;
    irq_active = 1; settle();
    chk("R7 boosted by active", clk_slow, 0);
    irq_active = 0; settle();
    chk("R9 reduced again", clk_slow, 1);
    irq_pend = 4'b1000; settle();
    chk("R7 boosted by pending", clk_slow, 0);
    irq_pend = '0; settle();
    chk("R9 reduced after pending", clk_div_sel, 6);
  endtask

  task automatic t_stop();
    wr(2, 0, 0, 4); settle();
    chk("R4 stop", clk_stop, 1);
    chk("R4 slow off", clk_slow, 0);
    irq_pend = 4'b0100; settle();
    chk("R5 woke", clk_stop, 0);
    irq_pend = '0; settle();
    chk("R5 stays full", outs(), 0);
    wr(3, 0, 0, 1); settle();
    chk("R2 code 3 full", outs(), 0);
  endtask

  task automatic t_write_beats_wake();
    wr(2, 0, 0, 0); settle();
    cfg_wdata = {3'd7, 1'b0, 1'b0, 2'd1};
    cfg_we = 1; irq_pend = 4'b0001;
    tick();
    cfg_we = 0;
    settle();
    chk("R12 write wins", outs(), 'b01111);
    irq_pend = '0; settle();
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    #1;
    t_reset();
    t_handshake();
    t_reset_sb_off();
    t_uart_boost();
    t_irq_boost();
    t_stop();
    t_write_beats_wake();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule